// File: doc/BRIEF.md
# Configuration Request TLP Packer

This block turns one configuration-space read or write into the three-doubleword header of a configuration request packet. It streams the packet out as 64-bit beats with start and end markers under a valid/ready handshake. A request carries a target bus, a device/function number, a byte offset, an access size (byte, halfword or word), write data and a read/write select. The block keeps its own copy of the root bus number. That copy selects between type 0 requests (target on the root bus) and type 1 requests (any other bus), and it forms the upper byte of the requester ID.

Before packing, the block screens each request. A request aimed at the root port's first base address register is refused with a bad-register status. A request aimed at a non-zero slot on the root bus, or on the bus directly below it, is refused as device-not-found. Refused requests produce no beats. Each request, accepted or refused, ends in a one-cycle `done` pulse with a status code. When a write to the primary bus number register of the root bus completes, the block loads the low byte of the write data into its root bus number copy.

Top module: `cfg_tlp_packer`

## Requirements
- R1: The format/type byte is 0x04 for a read and 0x44 for a write when the target bus equals the stored root bus number, and 0x05 for a read and 0x45 for a write on any other bus.
- R2: Header word 0 is the format/type byte in bits 31:24 with the value 1 in the length field (bits 9:0) and zeros elsewhere. Header word 1 has the requester ID {root bus, RP_DEVFN} in bits 31:16, the tag in bits 15:8 (0x1D for a read, 0x10 for a write) and the byte enables in bits 3:0.
- R3: Header word 2 holds the bus in bits 31:24, the device/function in bits 23:16, and the offset with its two low bits cleared in bits 15:0.
- R4: Size code 0 (byte) gives byte enables 1<<(offset&3). Code 1 (halfword) gives 3<<(offset&3), truncated to 4 bits. Codes 2 and 3 (word) give 0xF. Write data is masked to the access size and shifted left by 8*(offset&3); word data is not shifted. Read data is zero.
- R5: Every packet starts with a beat carrying header word 0 in tx_data[31:0] and header word 1 in tx_data[63:32], with tx_sop set. A read, or a write whose offset has a non-zero low three bits, then sends one final beat: header word 2 in bits 31:0, data in bits 63:32, tx_eop set.
- R6: A write whose offset has its low three bits at zero sends three beats. The second beat has header word 2 in bits 31:0, zero in bits 63:32, and neither flag. The third beat has the data in bits 31:0, zero in bits 63:32, and tx_eop set.
- R7: A request to offset 0x10 on the root bus with device/function 0 sends no beat and ends with status 1 (bad register).
- R8: Otherwise, a request whose slot (devfn[7:3]) is non-zero, on the root bus or on root bus + 1 (modulo 256), sends no beat and ends with status 2 (device not found).
- R9: When a write to offset 0x18 on the root bus completes, root_bus takes the low byte of the shifted write data, and it changes at no other time.
- R10: While tx_valid is high and tx_ready is low, tx_data, tx_sop and tx_eop hold their values.
- R11: busy is high from the cycle after a packet is accepted until the end beat has transferred. req_valid is ignored while busy is high.
- R12: done pulses for one cycle after the end beat transfers, or the cycle after a refused request is taken, with status 0 for a sent packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_addr | input | ADDR_W | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Packet in progress |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Beat accepted by the sink |
| tx_data | output | 64 | Beat payload |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | 0 ok, 1 bad register, 2 device not found |
| root_bus | output | 8 | Stored root bus number |

## Verification
The bench runs a near-exhaustive sweep over three target buses: the root bus, the bus below it, and an unrelated bus. Each bus is combined with four device/function values, nine offsets, every access size, and both directions. The bus choice tells type 0 apart from type 1 and shows where the slot filter applies. The offsets cover every byte lane, the qword-aligned and unaligned forms, the hidden BAR and the primary bus register. The sink's ready follows a fixed stall pattern, so beats are seen both held and taken. In the middle of a packet a stray request is injected, which shows whether requests are ignored while busy. The sweep reprograms the root bus partway through, so later requests check type selection against the new value.

// File: rtl/cfg_tlp_pkg.sv
// Shared types of the configuration TLP packer.
package cfg_tlp_pkg;
    typedef enum logic [1:0] {
        CST_OK     = 2'd0,
        CST_BADREG = 2'd1,
        CST_NODEV  = 2'd2
    } cfg_status_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } cfg_size_e;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_B1   = 2'd1,
        PK_B2   = 2'd2,
        PK_B3   = 2'd3
    } pk_state_e;
endpackage

// File: rtl/cfg_req_filter.sv
// Screens a configuration request before it is packed.
// Assumes: root_bus is the currently stored root bus number.
// The hidden-BAR check has priority over the slot check.
module cfg_req_filter
    import cfg_tlp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BAR0_OFS = 'h10
) (
    input  logic [7:0]        bus,
    input  logic [7:0]        devfn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        root_bus,
    output cfg_status_e       verdict
);
    localparam logic [ADDR_W-1:0] BAR0_A = ADDR_W'(BAR0_OFS);

    logic on_root, below_root, hide_bar;

    // Classify the target bus and pick a verdict.
    always_comb begin
        on_root    = (bus == root_bus);
        below_root = (bus == 8'(root_bus + 8'd1));
        hide_bar   = on_root && (devfn == 8'd0) && (addr == BAR0_A);
        if (hide_bar)
            verdict = CST_BADREG;
        else if ((on_root || below_root) && (devfn[7:3] != 5'd0))
            verdict = CST_NODEV;
        else
            verdict = CST_OK;
    end
endmodule

// File: rtl/cfg_hdr_build.sv
// Forms the three header words and the lane-shifted payload of a
// configuration request. Purely combinational.
// Assumes: ADDR_W <= 16.
module cfg_hdr_build
    import cfg_tlp_pkg::*;
#(
    parameter int           ADDR_W   = 12,
    parameter logic [7:0]   RP_DEVFN = 8'h00
) (
    input  logic              wr,
    input  logic [7:0]        bus,
    input  logic [7:0]        devfn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    input  logic [7:0]        root_bus,
    output logic [31:0]       hdr0,
    output logic [31:0]       hdr1,
    output logic [31:0]       hdr2,
    output logic [31:0]       data,
    output logic              qw_split
);
    localparam logic [7:0] TAG_RD = 8'h1D;
    localparam logic [7:0] TAG_WR = 8'h10;

    logic [1:0]  lane;
    logic [4:0]  shamt;
    logic [3:0]  be;
    logic [7:0]  fmt;
    logic [31:0] wshift;

    // Byte enables and lane-shifted write data from size and offset.
    always_comb begin
        lane  = addr[1:0];
        shamt = {lane, 3'b000};
        case (size)
            SZ_BYTE: begin
                be     = 4'b0001 << lane;
                wshift = {24'd0, wdata[7:0]} << shamt;
            end
            SZ_HALF: begin
                be     = 4'b0011 << lane;
                wshift = {16'd0, wdata[15:0]} << shamt;
            end
            default: begin
                be     = 4'hF;
                wshift = wdata;
            end
        endcase
    end

    // Header words, type selection and beat-split decision.
    always_comb begin
        fmt      = {1'b0, wr, 5'b00010, (bus != root_bus)};
        hdr0     = {fmt, 14'd0, 10'd1};
        hdr1     = {root_bus, RP_DEVFN, (wr ? TAG_WR : TAG_RD), 4'd0, be};
        hdr2     = {bus, devfn, 16'({addr[ADDR_W-1:2], 2'b00})};
        data     = wr ? wshift : 32'd0;
        qw_split = wr && (addr[2:0] == 3'd0);
    end
endmodule

// File: rtl/cfg_tlp_packer.sv
// Top: takes one configuration request at a time, screens it, and
// sends the packet as 64-bit beats under valid/ready.
// Assumes: requests arriving while busy are dropped by design; the
// root bus copy starts at ROOT_BUS_INIT after reset.
module cfg_tlp_packer
    import cfg_tlp_pkg::*;
#(
    parameter int         ADDR_W        = 12,
    parameter logic [7:0] ROOT_BUS_INIT = 8'h00,
    parameter logic [7:0] RP_DEVFN      = 8'h00,
    parameter int         BAR0_OFS      = 'h10,
    parameter int         PRIBUS_OFS    = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_bus,
    input  logic [7:0]        req_devfn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [63:0]       tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              done,
    output logic [1:0]        status,
    output logic [7:0]        root_bus
);
    localparam logic [ADDR_W-1:0] PRIBUS_A = ADDR_W'(PRIBUS_OFS);

    pk_state_e   state;
    cfg_status_e verdict;
    logic [31:0] h0_c, h1_c, h2_c, d_c;
    logic        split_c;
    logic [31:0] h0_q, h1_q, h2_q, d_q;
    logic        split_q, upd_q;
    logic [7:0]  root_q;
    logic        take, last_beat;

    cfg_req_filter #(.ADDR_W(ADDR_W), .BAR0_OFS(BAR0_OFS)) u_filt (
        .bus(req_bus), .devfn(req_devfn), .addr(req_addr),
        .root_bus(root_q), .verdict(verdict)
    );

    cfg_hdr_build #(.ADDR_W(ADDR_W), .RP_DEVFN(RP_DEVFN)) u_hdr (
        .wr(req_write), .bus(req_bus), .devfn(req_devfn), .addr(req_addr),
        .size(req_size), .wdata(req_wdata), .root_bus(root_q),
        .hdr0(h0_c), .hdr1(h1_c), .hdr2(h2_c), .data(d_c), .qw_split(split_c)
    );

    // Request acceptance and detection of the final handshake.
    always_comb begin
        take      = req_valid && (state == PK_IDLE);
        last_beat = tx_valid && tx_ready && tx_eop;
    end

    // Sequencer, latched packet contents, done/status and root bus copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PK_IDLE;
            h0_q    <= '0;
            h1_q    <= '0;
            h2_q    <= '0;
            d_q     <= '0;
            split_q <= 1'b0;
            upd_q   <= 1'b0;
            root_q  <= ROOT_BUS_INIT;
            done    <= 1'b0;
            status  <= CST_OK;
        end else begin
            done <= 1'b0;
            if (take) begin
                if (verdict != CST_OK) begin
                    done   <= 1'b1;
                    status <= verdict;
                end else begin
                    state   <= PK_B1;
                    h0_q    <= h0_c;
                    h1_q    <= h1_c;
                    h2_q    <= h2_c;
                    d_q     <= d_c;
                    split_q <= split_c;
                    upd_q   <= req_write && (req_bus == root_q)
                               && (req_addr == PRIBUS_A);
                end
            end else if (tx_valid && tx_ready) begin
                case (state)
                    PK_B1:   state <= PK_B2;
                    PK_B2:   state <= split_q ? PK_B3 : PK_IDLE;
                    default: state <= PK_IDLE;
                endcase
                if (last_beat) begin
                    done   <= 1'b1;
                    status <= CST_OK;
                    if (upd_q)
                        root_q <= d_q[7:0];
                end
            end
        end
    end

    // Beat contents and flags from the current sequencer step.
    always_comb begin
        tx_valid = (state != PK_IDLE);
        busy     = tx_valid;
        tx_sop   = (state == PK_B1);
        tx_eop   = ((state == PK_B2) && !split_q) || (state == PK_B3);
        root_bus = root_q;
        case (state)
            PK_B1:   tx_data = {h1_q, h0_q};
            PK_B2:   tx_data = split_q ? {32'd0, h2_q} : {d_q, h2_q};
            PK_B3:   tx_data = {32'd0, d_q};
            default: tx_data = '0;
        endcase
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                     && $stable(tx_sop) && $stable(tx_eop)));

    // R5
    sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx_valid && tx_sop && !tx_eop));

    // R9
    root_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(root_bus) |-> (done && status == CST_OK));

    // R7 R8
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != CST_OK) |-> !tx_valid);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == CST_OK) |-> !busy);
endmodule

// File: tb/sim_cfg_tlp_packer.sv
module sim_cfg_tlp_packer;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [7:0]        req_bus = '0;
    logic [7:0]        req_devfn = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [31:0]       req_wdata = '0;
    logic              busy, tx_valid, tx_sop, tx_eop, done;
    logic              tx_ready = 1'b0;
    logic [63:0]       tx_data;
    logic [1:0]        status;
    logic [7:0]        root_bus;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [7:0] m_root = 8'h00;

    cfg_tlp_packer #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .busy(busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .done(done), .status(status),
        .root_bus(root_bus)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of one request: status, beats, root bus afterwards.
    task automatic model(input bit w, input logic [7:0] b, input logic [7:0] df,
                         input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [1:0] st,
                         output int nb, output logic [63:0] bt [3],
                         output logic [7:0] root_after);
        logic [7:0] fmt, tag;
        logic [3:0] be;
        logic [31:0] dat, h0, h1, h2;
        int sh;
        sh = 8 * int'(a[1:0]);
        if (b == m_root && df == 8'd0 && a == 12'h010) st = 2'd1;
        else if ((b == m_root || b == 8'(m_root + 1)) && df[7:3] != 0) st = 2'd2;
        else st = 2'd0;
        if (b == m_root) fmt = w ? 8'h44 : 8'h04;
        else fmt = w ? 8'h45 : 8'h05;
        tag = w ? 8'h10 : 8'h1D;
        if (sz == 2'd0) begin be = 4'((1 << a[1:0]) & 15); dat = (wd & 32'hFF) << sh; end
        else if (sz == 2'd1) begin be = 4'((3 << a[1:0]) & 15); dat = (wd & 32'hFFFF) << sh; end
        else begin be = 4'hF; dat = wd; end
        if (!w) dat = 32'd0;
        h0 = (32'(fmt) << 24) | 32'd1;
        h1 = (32'(m_root) << 24) | (32'(tag) << 8) | 32'(be);
        h2 = (32'(b) << 24) | (32'(df) << 16) | 32'(a & 12'hFFC);
        bt[0] = {h1, h0};
        if (w && a[2:0] == 3'd0) begin
            nb = 3; bt[1] = {32'd0, h2}; bt[2] = {32'd0, dat};
        end else begin
            nb = 2; bt[1] = {dat, h2}; bt[2] = '0;
        end
        if (st != 2'd0) nb = 0;
        root_after = (st == 2'd0 && w && b == m_root && a == 12'h018) ? dat[7:0] : m_root;
    endtask

    task automatic run_req(input bit w, input logic [7:0] b, input logic [7:0] df,
                           input logic [11:0] a, input logic [1:0] sz,
                           input logic [31:0] wd);
        logic [1:0] est;
        int nb, got;
        logic [63:0] bt [3];
        logic [7:0] ra;
        logic [63:0] held;
        bit stalled, injected, inj_on, seen_done;
        string rt;
        model(w, b, df, a, sz, wd, est, nb, bt, ra);
        rt = (nb == 3) ? "R6" : "R5";
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_bus = b; req_devfn = df;
        req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (est != 2'd0) begin
            chk(est == 2'd1 ? "R7 status" : "R8 status", done && status == est,
                64'(status), 64'(est));
            chk("R7 R8 no beat", !tx_valid && !busy, 64'(tx_valid), 64'd0);
        end else begin
            chk("R11 busy after accept", busy === 1'b1, 64'(busy), 64'd1);
            got = 0; stalled = 0; injected = 0; inj_on = 0; seen_done = 0;
            for (int k = 0; k < 40; k++) begin
                if (inj_on) begin req_valid = 1'b0; inj_on = 0; end
                if (done) begin seen_done = 1; break; end
                if (stalled)
                    chk("R10 hold", tx_valid && tx_data == held, tx_data, held);
                tx_ready = (cyc % 3) != 1;
                stalled = 0;
                if (tx_valid) begin
                    if (tx_ready) begin
                        if (got < nb) begin
                            chk(got == 0 ? "R2 R5 beat0" : rt, tx_data == bt[got],
                                tx_data, bt[got]);
                            chk("R5 R6 flags", tx_sop == (got == 0) && tx_eop == (got == nb - 1),
                                64'({tx_sop, tx_eop}), 64'({got == 0, got == nb - 1}));
                        end else chk("R5 R6 extra beat", 1'b0, 64'(got), 64'(nb));
                        got++;
                    end else begin
                        stalled = 1; held = tx_data;
                    end
                    if (!injected && got == 1) begin
                        // R11: stray request while busy must be ignored
                        req_valid = 1'b1; req_bus = m_root; req_devfn = 8'd0;
                        req_addr = 12'h010; injected = 1; inj_on = 1;
                    end
                end
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk("R12 done seen", seen_done, 64'(seen_done), 64'd1);
            chk("R12 status ok", status == 2'd0, 64'(status), 64'd0);
            chk("R11 beat count", got == nb, 64'(got), 64'(nb));
            chk("R11 idle at done", !busy, 64'(busy), 64'd0);
        end
        chk("R9 root bus", root_bus == ra, 64'(root_bus), 64'(ra));
        m_root = ra;
        @(negedge clk);
        chk("R12 single pulse", !done && !tx_valid, 64'({done, tx_valid}), 64'd0);
    endtask

    initial begin
        logic [11:0] offs [9] = '{12'h000, 12'h001, 12'h002, 12'h003, 12'h004,
                                   12'h010, 12'h018, 12'h03C, 12'h013};
        logic [7:0] dfs [4] = '{8'h00, 8'h01, 8'h08, 8'hFF};
        int n = 0;
        repeat (3) @(negedge clk);
        chk("R12 reset", !done && !busy && !tx_valid && root_bus == 8'h00,
            64'({done, busy, tx_valid, root_bus}), 64'd0);
        rst_n = 1'b1;
        // R1 R3 R4: sweep across bus, devfn, offset, size, direction
        for (int bi = 0; bi < 3; bi++)
            for (int di = 0; di < 4; di++)
                for (int oi = 0; oi < 9; oi++)
                    for (int s = 0; s < 3; s++)
                        for (int w = 0; w < 2; w++) begin
                            logic [7:0] bsel;
                            bsel = (bi == 0) ? m_root : (bi == 1) ? 8'(m_root + 1) : 8'(m_root + 5);
                            n++;
                            run_req(w[0], bsel, dfs[di], offs[oi], 2'(s),
                                    32'h9E3779B9 * 32'(n));
                        end
        // R9: explicit root bus reprogramming, then type 0 on the new bus
        run_req(1'b1, m_root, 8'h00, 12'h018, 2'd2, 32'h0000_0042);
        run_req(1'b0, 8'h42, 8'h00, 12'h000, 2'd2, 32'h0);
        run_req(1'b0, 8'h00, 8'h00, 12'h004, 2'd3, 32'h0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule